// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block sits between the status logic of a UART and the processor. It takes the condition signals of five interrupt sources (receiver line status, received data available, character timeout, transmit holding register empty and modem status), masks each with a bit of its own enable register, and reports the single most urgent pending source in an identification byte. The same state drives one active-high interrupt line towards the interrupt controller.

The block also owns the clearing rules. Line-status and modem-status events are held until their status registers are read. A character timeout is held until the receive buffer is read. The holding-register-empty interrupt is armed when the transmitter becomes empty while enabled. It is dropped when software writes the holding register, or when software reads the identification byte while that interrupt is the one being reported. Received data available follows the receive-level condition directly. The conditions themselves are produced elsewhere; this block only latches, masks, prioritises and clears.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register is written with `ien_we`/`ien_wdata` and read on `ien_rdata`; bit 0 enables received data available, bit 1 holding-register empty, bit 2 line status, bit 3 modem status; bits 7:4 always read 0; reset value 0x00.
- R2: `iir_o` bit 0 is 0 when an enabled source is pending and 1 otherwise; `irq_o` is high exactly when an enabled source is pending; after reset `iir_o` is 0x01 and `irq_o` is 0.
- R3: The reported code sits in `iir_o` bits 3:1; priority from high to low is line status (011), received data available (010) and character timeout (110), holding-register empty (001), modem status (000); with no source pending bits 3:1 are 000.
- R4: When received data available and character timeout are both pending and enabled, code 010 is reported.
- R5: A disabled source is not reported and does not raise `irq_o`, but a latched line-status, timeout, or modem event stays pending and appears once its enable bit is set.
- R6: `iir_o` bits 7:6 read 11 while `fifo_en` is high and 00 otherwise; bits 5:4 always read 00.
- R7: A pending holding-register-empty interrupt clears on `thr_wr`, or on `iir_rd` in a cycle where code 001 is the reported pending source; an `iir_rd` while another source is reported leaves it pending.
- R8: The holding-register-empty interrupt is armed one cycle after `thr_empty` rises while bit 1 is enabled, or two cycles after bit 1 is written to 1 while `thr_empty` is high.
- R9: A line-status event (`ls_evt`) stays pending until `lsr_rd`; a modem event (`ms_evt`) stays pending until `msr_rd`; reads of the other registers do not clear them; an event in the same cycle as its clearing read wins.
- R10: Received data available follows the `rx_trig` level in the same cycle; a timeout event (`to_evt`) stays pending until `rbr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_rdata | output | 8 | Enable register read data |
| fifo_en | input | 1 | FIFO mode flag |
| ls_evt | input | 1 | Line-status error event pulse |
| rx_trig | input | 1 | Receive level at or above threshold (level) |
| to_evt | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| ms_evt | input | 1 | Modem input change event pulse |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench stacks every source at once and peels them off one clearing action at a time, so a wrong priority order or a swapped code shows up as the wrong byte at some step. It reads the identification byte while line status is reported and later checks that the holding-register-empty interrupt survived; a design clearing it on any read would lose it there. Masked events are raised and then unmasked, catching a design that drops events while disabled, and enabling the transmitter interrupt while already empty catches one that arms only on the empty edge. Strobes for the wrong register are applied to modem status to catch over-eager clearing.

// File: rtl/uii_pkg.sv
package uii_pkg;
    localparam int REG_W = 8;
    localparam int EN_W  = 4;
    localparam int ID_W  = 3;

    localparam int EN_RDA  = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;

    typedef enum logic [ID_W-1:0] {
        ID_MS   = 3'b000,
        ID_THRE = 3'b001,
        ID_RDA  = 3'b010,
        ID_LS   = 3'b011,
        ID_TO   = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic ls;
        logic to;
        logic thre;
        logic ms;
        logic thre_gate;
    } track_t;
endpackage

// File: rtl/uii_enable_reg.sv
module uii_enable_reg
    import uii_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [EN_W-1:0]  en
);
    logic [EN_W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (we) en_d = wdata[EN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;
endmodule

// File: rtl/uii_src_track.sv
module uii_src_track
    import uii_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ls_evt,
    input  logic to_evt,
    input  logic ms_evt,
    input  logic thr_empty,
    input  logic thre_en,
    input  logic thre_ack,
    input  logic thr_wr,
    input  logic lsr_rd,
    input  logic rbr_rd,
    input  logic msr_rd,
    output logic ls_p,
    output logic to_p,
    output logic thre_p,
    output logic ms_p
);
    track_t trk_d, trk_q;
    logic   thre_rise;

    always_comb begin
        trk_d           = trk_q;
        trk_d.thre_gate = thr_empty & thre_en;
        thre_rise       = trk_d.thre_gate & ~trk_q.thre_gate;

        // new events take precedence over a clearing access in the same cycle
        if (ls_evt)      trk_d.ls = 1'b1;
        else if (lsr_rd) trk_d.ls = 1'b0;

        if (to_evt)      trk_d.to = 1'b1;
        else if (rbr_rd) trk_d.to = 1'b0;

        if (ms_evt)      trk_d.ms = 1'b1;
        else if (msr_rd) trk_d.ms = 1'b0;

        if (thre_rise)                trk_d.thre = 1'b1;
        else if (thr_wr || thre_ack)  trk_d.thre = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ls_p   = trk_q.ls;
    assign to_p   = trk_q.to;
    assign thre_p = trk_q.thre;
    assign ms_p   = trk_q.ms;
endmodule

// File: rtl/uii_prio_enc.sv
module uii_prio_enc
    import uii_pkg::*;
(
    input  logic [EN_W-1:0] en,
    input  logic            ls_p,
    input  logic            rda,
    input  logic            to_p,
    input  logic            thre_p,
    input  logic            ms_p,
    output irq_id_e         id,
    output logic            pend
);
    always_comb begin
        id   = ID_MS;
        pend = 1'b1;
        if (ls_p && en[EN_LS])          id = ID_LS;
        else if (rda && en[EN_RDA])     id = ID_RDA;
        else if (to_p && en[EN_RDA])    id = ID_TO;
        else if (thre_p && en[EN_THRE]) id = ID_THRE;
        else if (ms_p && en[EN_MS])     id = ID_MS;
        else                            pend = 1'b0;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uii_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic [REG_W-1:0] ien_wdata,
    output logic [REG_W-1:0] ien_rdata,
    input  logic             fifo_en,
    input  logic             ls_evt,
    input  logic             rx_trig,
    input  logic             to_evt,
    input  logic             thr_empty,
    input  logic             ms_evt,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             msr_rd,
    output logic [REG_W-1:0] iir_o,
    output logic             irq_o
);
    localparam int PAD_W = REG_W - EN_W;

    logic [EN_W-1:0] en;
    logic            ls_p, to_p, thre_p, ms_p;
    irq_id_e         cur_id;
    logic            any_pend;
    logic            thre_ack;

    uii_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ien_we),
        .wdata (ien_wdata),
        .en    (en)
    );

    uii_src_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ls_evt    (ls_evt),
        .to_evt    (to_evt),
        .ms_evt    (ms_evt),
        .thr_empty (thr_empty),
        .thre_en   (en[EN_THRE]),
        .thre_ack  (thre_ack),
        .thr_wr    (thr_wr),
        .lsr_rd    (lsr_rd),
        .rbr_rd    (rbr_rd),
        .msr_rd    (msr_rd),
        .ls_p      (ls_p),
        .to_p      (to_p),
        .thre_p    (thre_p),
        .ms_p      (ms_p)
    );

    uii_prio_enc u_enc (
        .en     (en),
        .ls_p   (ls_p),
        .rda    (rx_trig),
        .to_p   (to_p),
        .thre_p (thre_p),
        .ms_p   (ms_p),
        .id     (cur_id),
        .pend   (any_pend)
    );

    assign thre_ack  = iir_rd & any_pend & (cur_id == ID_THRE);
    assign ien_rdata = {{PAD_W{1'b0}}, en};
    assign iir_o     = {{2{fifo_en}}, 2'b00, cur_id, ~any_pend};
    assign irq_o     = any_pend;
endmodule

// File: rtl/uii_checker.sv
module uii_checker
    import uii_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ien_we,
    input logic [REG_W-1:0] ien_wdata,
    input logic [REG_W-1:0] ien_rdata,
    input logic             thr_empty,
    input logic             ls_evt,
    input logic             ms_evt,
    input logic             iir_rd,
    input logic             msr_rd,
    input logic [REG_W-1:0] iir_o,
    input logic             irq_o
);
    // R1
    ien_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we |=> ien_rdata == {4'b0000, $past(ien_wdata[3:0])});

    // R3
    ls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_evt && ien_rdata[2] && !ien_we) |=> (iir_o[3:0] == 4'b0110));

    // R7
    thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !iir_o[0] && iir_o[3:1] == 3'b001 && thr_empty && $past(thr_empty)
         && !ien_we && !$past(ien_we))
        |=> !(iir_o[3:1] == 3'b001 && !iir_o[0]));

    // R9
    ms_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !ms_evt && !iir_o[0] && iir_o[3:1] == 3'b000)
        |=> (iir_o[0] || iir_o[3:1] != 3'b000));

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_rdata[3:0] == 4'b0000) |-> !irq_o);
endmodule

bind uart_irq_ident uii_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .ien_rdata (ien_rdata),
    .thr_empty (thr_empty),
    .ls_evt    (ls_evt),
    .ms_evt    (ms_evt),
    .iir_rd    (iir_rd),
    .msr_rd    (msr_rd),
    .iir_o     (iir_o),
    .irq_o     (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ien_we;
    logic [7:0] ien_wdata;
    logic [7:0] ien_rdata;
    logic       fifo_en, ls_evt, rx_trig, to_evt, thr_empty, ms_evt;
    logic       iir_rd, thr_wr, lsr_rd, rbr_rd, msr_rd;
    logic [7:0] iir_o;
    logic       irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .ien_rdata(ien_rdata), .fifo_en(fifo_en), .ls_evt(ls_evt),
        .rx_trig(rx_trig), .to_evt(to_evt), .thr_empty(thr_empty),
        .ms_evt(ms_evt), .iir_rd(iir_rd), .thr_wr(thr_wr), .lsr_rd(lsr_rd),
        .rbr_rd(rbr_rd), .msr_rd(msr_rd), .iir_o(iir_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // strobe codes: 0 iir_rd, 1 thr_wr, 2 lsr_rd, 3 rbr_rd, 4 msr_rd, 5 ls_evt, 6 to_evt, 7 ms_evt
    task automatic pulse(input int which);
        case (which)
            0: iir_rd = 1'b1;
            1: thr_wr = 1'b1;
            2: lsr_rd = 1'b1;
            3: rbr_rd = 1'b1;
            4: msr_rd = 1'b1;
            5: ls_evt = 1'b1;
            6: to_evt = 1'b1;
            default: ms_evt = 1'b1;
        endcase
        tick();
        {iir_rd, thr_wr, lsr_rd, rbr_rd, msr_rd, ls_evt, to_evt, ms_evt} = '0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        ien_we = 1'b1; ien_wdata = v;
        tick();
        ien_we = 1'b0; ien_wdata = 8'h00;
    endtask

    task automatic t_reset();
        chk("R2 reset iir", iir_o, 8'h01);
        chk("R2 reset irq", {7'b0, irq_o}, 8'h00);
        chk("R1 reset enables", ien_rdata, 8'h00);
    endtask

    task automatic t_enable_reg();
        wr_en(8'hFF);
        chk("R1 upper enable bits read zero", ien_rdata, 8'h0F);
        wr_en(8'h00);
        chk("R1 enables cleared", ien_rdata, 8'h00);
    endtask

    task automatic t_thre();
        wr_en(8'h02);
        thr_empty = 1'b1; tick();
        chk("R8 arm on empty edge", iir_o, 8'h02);
        chk("R2 irq with thre", {7'b0, irq_o}, 8'h01);
        pulse(0);
        chk("R7 iir read clears thre", iir_o, 8'h01);
        thr_empty = 1'b0; tick();
        thr_empty = 1'b1; tick();
        chk("R8 re-arm after refill", iir_o, 8'h02);
        pulse(1);
        chk("R7 holding write clears thre", iir_o, 8'h01);
        wr_en(8'h00);
        wr_en(8'h02);
        tick();
        chk("R8 arm on enable while empty", iir_o, 8'h02);
        pulse(0);
        chk("R7 clear after enable arm", iir_o, 8'h01);
    endtask

    task automatic t_modem();
        wr_en(8'h0A);
        pulse(7);
        chk("R3 modem code", iir_o, 8'h00);
        chk("R2 irq with modem", {7'b0, irq_o}, 8'h01);
        pulse(0);
        chk("R9 iir read keeps modem", iir_o, 8'h00);
        pulse(2);
        chk("R9 line read keeps modem", iir_o, 8'h00);
        pulse(4);
        chk("R9 modem read clears", iir_o, 8'h01);
    endtask

    task automatic t_priority();
        wr_en(8'h0F);
        pulse(5);
        pulse(6);
        pulse(7);
        rx_trig = 1'b1;
        thr_empty = 1'b0; tick();
        thr_empty = 1'b1; tick();
        chk("R3 line status highest", iir_o, 8'h06);
        pulse(0);
        chk("R7 iir read during line status", iir_o, 8'h06);
        pulse(2);
        chk("R4 data available over timeout", iir_o, 8'h04);
        rx_trig = 1'b0; #1;
        chk("R10 data available follows level", iir_o, 8'h0C);
        tick();
        pulse(3);
        chk("R7 thre kept after earlier read", iir_o, 8'h02);
        pulse(0);
        chk("R3 modem lowest", iir_o, 8'h00);
        pulse(4);
        chk("R2 all cleared", iir_o, 8'h01);
    endtask

    task automatic t_mask();
        wr_en(8'h00);
        pulse(5);
        chk("R5 masked line status", iir_o, 8'h01);
        chk("R5 masked irq low", {7'b0, irq_o}, 8'h00);
        rx_trig = 1'b1; tick();
        chk("R5 masked data available", iir_o, 8'h01);
        wr_en(8'h04);
        chk("R5 latched line status appears", iir_o, 8'h06);
        wr_en(8'h01);
        chk("R5 data available when line masked", iir_o, 8'h04);
        rx_trig = 1'b0; tick();
        pulse(2);
        wr_en(8'h04);
        chk("R9 line read cleared masked event", iir_o, 8'h01);
        wr_en(8'h01);
        pulse(6);
        chk("R10 timeout latched", iir_o, 8'h0C);
        pulse(2);
        chk("R10 line read keeps timeout", iir_o, 8'h0C);
        pulse(3);
        chk("R10 buffer read clears timeout", iir_o, 8'h01);
        wr_en(8'h00);
    endtask

    task automatic t_fifo();
        fifo_en = 1'b1; tick();
        chk("R6 fifo bits idle", iir_o, 8'hC1);
        wr_en(8'h08);
        pulse(7);
        chk("R6 fifo bits with modem", iir_o, 8'hC0);
        pulse(4);
        fifo_en = 1'b0; tick();
        chk("R6 fifo bits off", iir_o, 8'h01);
        wr_en(8'h00);
    endtask

    initial begin
        rst_n = 1'b0; ien_we = 1'b0; ien_wdata = 8'h00;
        fifo_en = 1'b0; ls_evt = 1'b0; rx_trig = 1'b0; to_evt = 1'b0;
        thr_empty = 1'b0; ms_evt = 1'b0; iir_rd = 1'b0; thr_wr = 1'b0;
        lsr_rd = 1'b0; rbr_rd = 1'b0; msr_rd = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enable_reg();
        t_thre();
        t_modem();
        t_priority();
        t_mask();
        t_fifo();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule